// File: doc/BRIEF.md
# Exception Spawn Predictor

This block decides, for each exception type, whether an exception handler should be launched in a spare hardware thread or handled the conventional way by flushing and refetching. It holds one small saturating confidence counter per exception type. A handler that runs to its normal return raises the confidence for its type. A handler that gives up by issuing the hard-exception instruction lowers it. When confidence is low, the block predicts no-spawn, so that a spawn likely to be abandoned does not add latency. Because the counters move in both directions, the prediction follows shifts in behaviour, such as a burst of page faults.

Software supplies a per-type enable mask. A cleared bit forces conventional handling for that type, whatever its counter holds. The counter still trains while the bit is cleared. The pipeline presents an exception type on the lookup port, and the registered decision appears one cycle later.

Top module: `spawn_pred`

## Requirements
- R1: While reset is low, and in the first cycle after it, `pred_valid_o` and `pred_spawn_o` are 0. Every counter leaves reset at the weakly-spawn value: the most significant bit is 1 and all other bits are 0 (2 for a 2-bit counter). A first lookup of any enabled type therefore returns spawn.
- R2: `pred_valid_o` is 1 in exactly the cycles that follow a cycle with `lookup_valid_i` high.
- R3: When valid, `pred_spawn_o` is 1 if and only if, in the lookup cycle, the counter of `lookup_type_i` had its most significant bit set and bit `lookup_type_i` of `en_mask_i` was 1.
- R4: An update with `upd_hard_i` = 0 (normal completion) increments the counter of `upd_type_i`, saturating at the all-ones value.
- R5: An update with `upd_hard_i` = 1 (hard exception) decrements the counter of `upd_type_i`, saturating at 0.
- R6: An update changes only the counter of `upd_type_i`. Every other counter holds its value.
- R7: A 0 in `en_mask_i` for the looked-up type forces `pred_spawn_o` to 0. Updates for that type still train its counter, and the trained value shows once the bit is set again.
- R8: A lookup and an update of the same type in the same cycle give the decision from the counter value before the update. The updated value shows from the next lookup on.
- R9: `pred_spawn_o` is 0 whenever `pred_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_type_i | input | TYPE_W | Exception type to look up |
| upd_valid_i | input | 1 | Training event this cycle |
| upd_type_i | input | TYPE_W | Exception type being trained |
| upd_hard_i | input | 1 | 1: handler issued a hard exception; 0: handler returned normally |
| en_mask_i | input | NUM_TYPES | Software enable, one bit per type |
| pred_valid_o | output | 1 | Decision valid, one cycle after lookup |
| pred_spawn_o | output | 1 | 1: spawn in a separate thread; 0: conventional handling |

## Verification
On every cycle, the assertions check the counter stepping rules: a single step up or down, saturation at both ends, and holding when there is no update. They also check the one-cycle validity timing, the forcing effect of a cleared enable bit, and that the spawn output stays quiet without a valid decision. Other behaviours only show up through sequences, and the bench scenarios cover these. Among them are a burst of hard exceptions that drives a type to no-spawn and the normal returns that bring it back. The scenarios also cover isolation between types, training while masked, and the ordering of a lookup and an update in the same cycle.

// File: rtl/spawn_pred_pkg.sv
package spawn_pred_pkg;
  typedef enum logic {
    UPD_DONE = 1'b0,
    UPD_HARD = 1'b1
  } upd_kind_e;
endpackage

// File: rtl/spawn_pred_ctr.sv
module spawn_pred_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= CNT_INIT;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CTR_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R4
  AST_CTR_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_CTR_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q == '0) |=> cnt_q == '0); // R5
  AST_CTR_STEP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_CTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/spawn_pred_bank.sv
module spawn_pred_bank
  import spawn_pred_pkg::*;
#(
  parameter int NUM_TYPES = 16,
  parameter int CNT_W     = 2,
  parameter int TYPE_W    = $clog2(NUM_TYPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_valid_i,
  input  logic [TYPE_W-1:0]    upd_type_i,
  input  upd_kind_e            upd_kind_i,
  output logic [NUM_TYPES-1:0] msb_o
);
  logic [NUM_TYPES-1:0] inc, dec;

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_ctr
    logic [CNT_W-1:0] cnt;
    logic             hit;
    assign hit    = upd_valid_i && (upd_type_i == TYPE_W'(g));
    assign inc[g] = hit && (upd_kind_i == UPD_DONE);
    assign dec[g] = hit && (upd_kind_i == UPD_HARD);

    spawn_pred_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc[g]),
      .dec_i (dec[g]),
      .cnt_o (cnt)
    );
    assign msb_o[g] = cnt[CNT_W-1];
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |-> $countones(inc | dec) == 1); // R6
endmodule

// File: rtl/spawn_pred_lookup.sv
module spawn_pred_lookup #(
  parameter int NUM_TYPES = 16,
  parameter int TYPE_W    = $clog2(NUM_TYPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lookup_valid_i,
  input  logic [TYPE_W-1:0]    lookup_type_i,
  input  logic [NUM_TYPES-1:0] msb_i,
  input  logic [NUM_TYPES-1:0] en_i,
  output logic                 valid_o,
  output logic                 spawn_o
);
  logic valid_q, spawn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      spawn_q <= 1'b0;
    end else begin
      valid_q <= lookup_valid_i;
      spawn_q <= lookup_valid_i && msb_i[lookup_type_i] && en_i[lookup_type_i];
    end
  end

  assign valid_o = valid_q;
  assign spawn_o = spawn_q;

  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> valid_o); // R2
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !valid_o); // R2
  AST_LOW_CONF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !msb_i[lookup_type_i]) |=> !spawn_o); // R3
  AST_MASK_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !en_i[lookup_type_i]) |=> !spawn_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !spawn_o); // R9
endmodule

// File: rtl/spawn_pred.sv
module spawn_pred
  import spawn_pred_pkg::*;
#(
  parameter int NUM_TYPES = 16,
  parameter int CNT_W     = 2,
  parameter int TYPE_W    = $clog2(NUM_TYPES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lookup_valid_i,
  input  logic [TYPE_W-1:0]    lookup_type_i,
  input  logic                 upd_valid_i,
  input  logic [TYPE_W-1:0]    upd_type_i,
  input  logic                 upd_hard_i,
  input  logic [NUM_TYPES-1:0] en_mask_i,
  output logic                 pred_valid_o,
  output logic                 pred_spawn_o
);
  logic [NUM_TYPES-1:0] msb;
  upd_kind_e            upd_kind;

  assign upd_kind = upd_hard_i ? UPD_HARD : UPD_DONE;

  spawn_pred_bank #(.NUM_TYPES(NUM_TYPES), .CNT_W(CNT_W), .TYPE_W(TYPE_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_valid_i(upd_valid_i),
    .upd_type_i (upd_type_i),
    .upd_kind_i (upd_kind),
    .msb_o      (msb)
  );

  spawn_pred_lookup #(.NUM_TYPES(NUM_TYPES), .TYPE_W(TYPE_W)) u_lookup (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lookup_valid_i(lookup_valid_i),
    .lookup_type_i (lookup_type_i),
    .msb_i         (msb),
    .en_i          (en_mask_i),
    .valid_o       (pred_valid_o),
    .spawn_o       (pred_spawn_o)
  );
endmodule

// File: tb/spawn_pred_tb_top.sv
module spawn_pred_tb_top;
  localparam int NT   = 16;
  localparam int CW   = 2;
  localparam int TW   = $clog2(NT);
  localparam int CMAX = (1 << CW) - 1;
  localparam int CINI = 1 << (CW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lv = 1'b0, uv = 1'b0, uh = 1'b0;
  logic [TW-1:0] lt = '0, ut = '0;
  logic [NT-1:0] mask = '1;
  logic          pv, ps;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  spawn_pred #(.NUM_TYPES(NT), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lv), .lookup_type_i(lt),
    .upd_valid_i(uv), .upd_type_i(ut), .upd_hard_i(uh),
    .en_mask_i(mask),
    .pred_valid_o(pv), .pred_spawn_o(ps)
  );

  // behavioural reference
  int   ref_cnt [NT];
  logic exp_v, exp_s;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) ref_cnt[i] <= CINI;
      exp_v <= 1'b0;
      exp_s <= 1'b0;
    end else begin
      exp_v <= lv;
      exp_s <= lv && (ref_cnt[lt] >= CINI) && mask[lt];
      if (uv) begin
        if (!uh && ref_cnt[ut] < CMAX) ref_cnt[ut] <= ref_cnt[ut] + 1;
        if (uh && ref_cnt[ut] > 0)     ref_cnt[ut] <= ref_cnt[ut] - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at a negedge, wait one cycle, compare against the model
  task automatic cyc(input logic l_v, input int l_t, input logic u_v, input int u_t, input logic u_h);
    lv = l_v; lt = TW'(l_t); uv = u_v; ut = TW'(u_t); uh = u_h;
    @(negedge clk);
    chk("R2 model valid", pv, exp_v);
    chk("R3 model spawn", ps, exp_s);
  endtask

  task automatic look(input int t, input logic exp, input string tag);
    cyc(1'b1, t, 1'b0, 0, 1'b0);
    chk(tag, ps, exp);
  endtask

  task automatic upd(input int t, input logic hard, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b1, t, hard);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", pv, 1'b0);
    chk("R1 spawn in reset", ps, 1'b0);
    rst_n = 1'b1;
    cyc(1'b0, 0, 1'b0, 0, 1'b0);
    chk("R1 valid after reset", pv, 1'b0);
    for (int t = 0; t < NT; t++) look(t, 1'b1, "R1 weakly-spawn at reset");
    cyc(1'b0, 0, 1'b0, 0, 1'b0);
    chk("R2 no lookup no valid", pv, 1'b0);
    chk("R9 spawn quiet when idle", ps, 1'b0);

    // R5: hard exceptions lower confidence, saturate at 0
    upd(3, 1'b1, 1);
    look(3, 1'b0, "R5 one hard gives no-spawn");
    upd(3, 1'b1, 4);
    upd(3, 1'b0, 2);
    look(3, 1'b1, "R5 floor saturation then recover");
    look(4, 1'b1, "R6 neighbour untouched");
    look(2, 1'b1, "R6 neighbour untouched");

    // R4: normal returns raise confidence, saturate at max
    upd(5, 1'b0, 4);
    upd(5, 1'b1, 1);
    look(5, 1'b1, "R4 ceiling saturation");
    upd(5, 1'b1, 1);
    look(5, 1'b0, "R4 step down from ceiling");

    // R7: mask forces no-spawn, training continues
    mask[6] = 1'b0;
    look(6, 1'b0, "R7 masked type no-spawn");
    upd(6, 1'b1, 2);
    upd(6, 1'b0, 1);
    mask[6] = 1'b1;
    look(6, 1'b0, "R7 trained while masked");
    upd(6, 1'b0, 1);
    look(6, 1'b1, "R7 unmasked follows counter");

    // R8: same-cycle lookup and update
    cyc(1'b1, 7, 1'b1, 7, 1'b1);
    chk("R8 lookup sees old value", ps, 1'b1);
    look(7, 1'b0, "R8 update visible next lookup");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) mask = NT'($urandom);
      cyc(1'($urandom), int'($urandom_range(NT-1)), 1'($urandom),
          int'($urandom_range(NT-1)), 1'($urandom));
      if (!pv) chk("R9 quiet when not valid", ps, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule